// File: doc/BRIEF.md
# Programmable Forwarded Cache Clock Aligner

This block sits at the edge of an external cache port and lines up three groups of outgoing signals against the core clock. The index (address) outputs go first. The write-data outputs follow a programmable number of whole core-clock cycles later. A forwarded cache clock follows the data after a programmable number of half-cycle phases. This clock can also be switched off entirely. Together the two delays let the board route the heavily loaded index lines, the lightly loaded data lines and the forwarded clock with enough setup margin at the cache RAMs.

The forwarded clock has the core clock's period and is free running. It starts with the first transfer after reset or after a reconfiguration, and from then on it keeps toggling through idle cycles. The two configuration fields are taken into the active setting only while the port is idle. When a new setting is pending, the running clock is first brought to a clean stop with its output low. The new setting then applies from the next transfer on. Half-cycle delays come from falling-edge flops, so every output bit leaves a flop, and the clock output is the XOR of a flop pair.

Top module: `cache_port_aligner`

## Requirements
- R1: While `rst` is high at a rising edge, `addr_out`, `wdata_out` and `fclk_out` are driven low and every delay stage is cleared.
- R2: `addr_out` takes `addr_in` at each rising edge where `wr_valid` is high, and holds its value at every other edge. That edge is the launch edge L of the transfer.
- R3: With active data-delay code N (`cyc_dly`, unsigned 0 to 3), the write word appears on `wdata_out` for exactly the one cycle that starts at rising edge L+N.
- R4: In every cycle that is not the data slot of some transfer, `wdata_out` is zero.
- R5: With active clock code 0 (`fck_dly` = 2'b00), `fclk_out` stays low.
- R6: With clock code 1, 2 or 3, the first rising edge of `fclk_out` after a start comes 0, 1 or 2 half-cycle phases after rising edge L+N of the first transfer. Phase 1 falls on the falling edge. The largest offset is 3 cycles plus 2 phases.
- R7: Once started, `fclk_out` is high for one phase and low for the next in every core cycle, with unchanged phase alignment, including through idle cycles and later transfers.
- R8: A change on `cyc_dly` or `fck_dly` is applied only when no transfer is requested and no data is in flight. The running clock is first stopped with its output left low. After the stop, `fclk_out` stays low until the first transfer under the new setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Transfer request: launch the current address and write word |
| addr_in | input | AW | Index/address to launch |
| wdata_in | input | DW | Write word belonging to the address |
| cyc_dly | input | 2 | Address-to-data delay in whole cycles (0 to 3) |
| fck_dly | input | 2 | Data-to-clock delay code: 0 off, 1/2/3 give 0/1/2 phases |
| addr_out | output | AW | Launched address |
| wdata_out | output | DW | Delayed write word, zero outside its slot |
| fclk_out | output | 1 | Forwarded cache clock |

## Verification
The checker watches on every rising edge that the address is loaded and held around `wr_valid`. It also checks that a zero-cycle data delay passes the word straight through, that a non-zero data word always traces back to a request at most four cycles earlier, that the clock is low whenever the off code is active, and that the active setting only changes while the clock is stopped and no request is present. The phase placement of the first forwarded clock edge, the duty and alignment of the free-running clock, the slot of the data word for larger delays, and the clean stop and restart across a reconfiguration can only be seen in the bench's scenarios. There, a behavioural model predicts every output in every half cycle for all sixteen code pairs.

// File: rtl/cpa_pkg.sv
package cpa_pkg;

  localparam int CODE_W  = 2;
  localparam int MAX_CYC = (1 << CODE_W) - 1;

  typedef logic [CODE_W-1:0] cyc_code_t;

  typedef enum logic [CODE_W-1:0] {
    FCK_OFF = 2'd0,
    FCK_PH0 = 2'd1,
    FCK_PH1 = 2'd2,
    FCK_PH2 = 2'd3
  } fck_mode_e;

  localparam int NUM_VARIANTS = 3;

  typedef struct packed {
    cyc_code_t cyc;
    fck_mode_e fck;
  } port_cfg_t;

endpackage

// File: rtl/cpa_data_delay.sv
module cpa_data_delay
  import cpa_pkg::*;
#(
  parameter int DW     = 32,
  parameter int STAGES = MAX_CYC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic [DW-1:0] wdata_in,
  input  cyc_code_t     cyc_sel,
  output logic [DW-1:0] wdata_out,
  output logic          busy
);

  logic [STAGES-1:0] stg_v;
  logic [DW-1:0]     stg_d [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_v[0] <= 1'b0;
      stg_d[0] <= '0;
    end else begin
      stg_v[0] <= launch;
      stg_d[0] <= launch ? wdata_in : '0;
    end
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stg_v[i] <= 1'b0;
        stg_d[i] <= '0;
      end else begin
        stg_v[i] <= stg_v[i-1];
        stg_d[i] <= stg_d[i-1];
      end
    end
  end

  logic          pick_v;
  logic [DW-1:0] pick_d;

  always_comb begin
    pick_v = launch;
    pick_d = wdata_in;
    for (int k = 1; k <= STAGES; k++) begin
      if (int'(cyc_sel) == k) begin
        pick_v = stg_v[k-1];
        pick_d = stg_d[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wdata_out <= '0;
    else     wdata_out <= pick_v ? pick_d : '0;
  end

  assign busy = |stg_v;

endmodule

// File: rtl/cpa_run_ctrl.sv
module cpa_run_ctrl
  import cpa_pkg::*;
#(
  parameter int TAPS = MAX_CYC + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_valid,
  input  logic                    busy,
  input  logic                    gen_quiet,
  input  cyc_code_t               cyc_in,
  input  fck_mode_e               fck_in,
  output cyc_code_t               act_cyc,
  output fck_mode_e               act_fck,
  output logic                    run,
  output logic [NUM_VARIANTS-1:0] var_en
);

  port_cfg_t act_cfg;
  port_cfg_t req_cfg;
  logic      pend, idle, run_n, drained;
  logic [TAPS-1:0] tap;
  logic [TAPS-1:1] tap_q;

  assign req_cfg = '{cyc: cyc_in, fck: fck_in};
  assign pend    = (req_cfg != act_cfg);
  assign idle    = !wr_valid && !busy;

  always_comb begin
    if (wr_valid)          run_n = 1'b1;
    else if (idle && pend) run_n = 1'b0;
    else                   run_n = run;
  end

  always_ff @(posedge clk) begin
    if (rst) run <= 1'b0;
    else     run <= run_n;
  end

  assign tap[0] = run;

  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) tap_q[k] <= 1'b0;
      else     tap_q[k] <= tap[k-1];
    end
    assign tap[k] = tap_q[k];
  end

  assign drained = !run && !(|tap_q) && gen_quiet;

  always_ff @(posedge clk) begin
    if (rst)                           act_cfg <= req_cfg;
    else if (idle && pend && drained)  act_cfg <= req_cfg;
  end

  assign act_cyc = act_cfg.cyc;
  assign act_fck = act_cfg.fck;

  logic en_rise, en_fall;

  always_comb begin
    en_rise = run_n;
    en_fall = tap[0];
    for (int k = 1; k < TAPS; k++) begin
      if (int'(act_cfg.cyc) == k) begin
        en_rise = tap[k-1];
        en_fall = tap[k];
      end
    end
  end

  assign var_en[0] = (act_cfg.fck == FCK_PH0) && en_rise;
  assign var_en[1] = (act_cfg.fck == FCK_PH1) && en_fall;
  assign var_en[2] = (act_cfg.fck == FCK_PH2) && en_fall;

endmodule

// File: rtl/cpa_phase_gen.sv
module cpa_phase_gen
  import cpa_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_VARIANTS-1:0] var_en,
  input  fck_mode_e               mode,
  output logic                    fclk_out,
  output logic                    quiet
);

  logic [NUM_VARIANTS-1:0] tr_r;
  logic [NUM_VARIANTS-1:0] tr_f;
  logic [NUM_VARIANTS-1:0] wave;
  logic                    en_late;

  for (genvar v = 0; v < NUM_VARIANTS; v++) begin : g_var
    if (v == 0) begin : g_rise
      always_ff @(posedge clk) begin
        if (rst) tr_r[v] <= 1'b0;
        else     tr_r[v] <= var_en[v] ? ~tr_f[v] : tr_f[v];
      end
      always_ff @(negedge clk) begin
        if (rst) tr_f[v] <= 1'b0;
        else     tr_f[v] <= tr_r[v];
      end
    end else if (v == 1) begin : g_fall
      always_ff @(negedge clk) begin
        if (rst) tr_f[v] <= 1'b0;
        else     tr_f[v] <= var_en[v] ? ~tr_r[v] : tr_r[v];
      end
      always_ff @(posedge clk) begin
        if (rst) tr_r[v] <= 1'b0;
        else     tr_r[v] <= tr_f[v];
      end
    end else begin : g_fall_rise
      always_ff @(negedge clk) begin
        if (rst) en_late <= 1'b0;
        else     en_late <= var_en[v];
      end
      always_ff @(posedge clk) begin
        if (rst) tr_r[v] <= 1'b0;
        else     tr_r[v] <= en_late ? ~tr_f[v] : tr_f[v];
      end
      always_ff @(negedge clk) begin
        if (rst) tr_f[v] <= 1'b0;
        else     tr_f[v] <= tr_r[v];
      end
    end
    assign wave[v] = tr_r[v] ^ tr_f[v];
  end

  always_comb begin
    unique case (mode)
      FCK_PH0: fclk_out = wave[0];
      FCK_PH1: fclk_out = wave[1];
      FCK_PH2: fclk_out = wave[2];
      default: fclk_out = 1'b0;
    endcase
  end

  assign quiet = (wave == '0) && !en_late;

endmodule

// File: rtl/cache_port_aligner.sv
module cache_port_aligner
  import cpa_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic [1:0]    cyc_dly,
  input  logic [1:0]    fck_dly,
  output logic [AW-1:0] addr_out,
  output logic [DW-1:0] wdata_out,
  output logic          fclk_out
);

  cyc_code_t               act_cyc;
  fck_mode_e               act_fck;
  logic                    run;
  logic                    busy;
  logic                    gen_quiet;
  logic [NUM_VARIANTS-1:0] var_en;

  always_ff @(posedge clk) begin
    if (rst)           addr_out <= '0;
    else if (wr_valid) addr_out <= addr_in;
  end

  cpa_data_delay #(
    .DW     (DW),
    .STAGES (MAX_CYC)
  ) u_data (
    .clk       (clk),
    .rst       (rst),
    .launch    (wr_valid),
    .wdata_in  (wdata_in),
    .cyc_sel   (act_cyc),
    .wdata_out (wdata_out),
    .busy      (busy)
  );

  cpa_run_ctrl #(
    .TAPS (MAX_CYC + 1)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .busy      (busy),
    .gen_quiet (gen_quiet),
    .cyc_in    (cyc_code_t'(cyc_dly)),
    .fck_in    (fck_mode_e'(fck_dly)),
    .act_cyc   (act_cyc),
    .act_fck   (act_fck),
    .run       (run),
    .var_en    (var_en)
  );

  cpa_phase_gen u_phase (
    .clk      (clk),
    .rst      (rst),
    .var_en   (var_en),
    .mode     (act_fck),
    .fclk_out (fclk_out),
    .quiet    (gen_quiet)
  );

endmodule

// File: rtl/cache_port_aligner_chk.sv
module cache_port_aligner_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_valid,
  input logic [AW-1:0] addr_in,
  input logic [DW-1:0] wdata_in,
  input logic [AW-1:0] addr_out,
  input logic [DW-1:0] wdata_out,
  input logic          fclk_out,
  input logic [1:0]    act_cyc,
  input logic [1:0]    act_fck,
  input logic          run
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (addr_out == '0 && wdata_out == '0 && !fclk_out));

  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> addr_out == $past(addr_in));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> $stable(addr_out));

  // R3
  data_direct_chk: assert property (@(posedge clk) disable iff (rst)
    (act_cyc == 2'd0 && wr_valid) |=> wdata_out == $past(wdata_in));

  // R4
  data_origin_chk: assert property (@(posedge clk) disable iff (rst)
    (wdata_out != '0) |-> ($past(wr_valid) || $past(wr_valid, 2) ||
                           $past(wr_valid, 3) || $past(wr_valid, 4)));

  // R5
  clock_off_chk: assert property (@(posedge clk) disable iff (rst)
    act_fck == 2'd0 |-> !fclk_out);

  // R8
  cfg_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(act_cyc) || !$stable(act_fck)) |-> ($past(!run) && $past(!wr_valid)));

endmodule

bind cache_port_aligner cache_port_aligner_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_valid  (wr_valid),
  .addr_in   (addr_in),
  .wdata_in  (wdata_in),
  .addr_out  (addr_out),
  .wdata_out (wdata_out),
  .fclk_out  (fclk_out),
  .act_cyc   (act_cyc),
  .act_fck   (act_fck),
  .run       (run)
);

// File: tb/cache_port_aligner_test.sv
module cache_port_aligner_test;

  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] wdata_in = '0;
  logic [1:0]    cyc_dly = 2'd0;
  logic [1:0]    fck_dly = 2'd0;
  logic [AW-1:0] addr_out;
  logic [DW-1:0] wdata_out;
  logic          fclk_out;

  cache_port_aligner #(.AW(AW), .DW(DW)) uut (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .addr_in   (addr_in),
    .wdata_in  (wdata_in),
    .cyc_dly   (cyc_dly),
    .fck_dly   (fck_dly),
    .addr_out  (addr_out),
    .wdata_out (wdata_out),
    .fclk_out  (fclk_out)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit cmp_on = 0;
  bit fck_on = 0;
  bit done   = 0;

  logic [DW-1:0] dexp [int];
  logic [AW-1:0] amap [int];
  logic [AW-1:0] cur_addr = '0;
  int first_l = -1;
  int cur_n   = 0;
  int cur_c   = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  function automatic bit fclk_model(int s);
    int st;
    if (cur_c == 0 || first_l < 0) return 1'b0;
    st = 2 * (first_l + cur_n) + (cur_c - 1);
    if (s < st) return 1'b0;
    return ((s - st) % 2) == 0;
  endfunction

  task automatic compare(int c, int half);
    int s;
    string freq;
    logic [DW-1:0] ed;
    s = 2 * c + half;
    if (half == 0 && amap.exists(c)) cur_addr = amap[c];
    chk("R2 addr", 64'(addr_out), 64'(cur_addr));
    ed = dexp.exists(c) ? dexp[c] : '0;
    chk(dexp.exists(c) ? "R3 data slot" : "R4 data idle", 64'(wdata_out), 64'(ed));
    if (fck_on) begin
      if (cur_c == 0) freq = "R5 clock off";
      else if (first_l < 0) freq = "R8 stopped";
      else if (s < 2 * (first_l + cur_n) + cur_c + 1) freq = "R6 first edge";
      else freq = "R7 free run";
      chk(freq, 64'(fclk_out), 64'(fclk_model(s)));
    end
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    #2;
    if (cmp_on) compare(cyc, 0);
    @(negedge clk);
    #2;
    if (cmp_on) compare(cyc, 1);
  end

  task automatic launch(logic [AW-1:0] a, logic [DW-1:0] d);
    int l;
    @(negedge clk);
    wr_valid = 1'b1;
    addr_in  = a;
    wdata_in = d;
    l = cyc + 1;
    amap[l] = a;
    dexp[l + cur_n] = d;
    if (first_l < 0) first_l = l;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    wr_valid = 1'b0;
    addr_in  = '1;
    wdata_in = '1;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic set_cfg(int n, int c);
    @(negedge clk);
    fck_on  = 0;
    cyc_dly = 2'(n);
    fck_dly = 2'(c);
    repeat (10) @(negedge clk);
    cur_n   = n;
    cur_c   = c;
    first_l = -1;
    fck_on  = 1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #2;
    // R1: outputs low straight after reset
    chk("R1 addr", 64'(addr_out), 64'd0);
    chk("R1 data", 64'(wdata_out), 64'd0);
    chk("R1 clock", 64'(fclk_out), 64'd0);
    cmp_on = 1;
    fck_on = 1;
    for (int n = 0; n < 4; n++) begin
      for (int c = 0; c < 4; c++) begin
        set_cfg(n, c);
        launch(AW'(16'h1000 + n * 16 + c), DW'(32'hA000_0000 + n * 256 + c * 16 + 1));
        launch(AW'(16'h2000 + n * 16 + c), DW'(32'hB000_0000 + n * 256 + c * 16 + 2));
        launch(AW'(16'h3000 + n * 16 + c), DW'(32'hC000_0000 + n * 256 + c * 16 + 3));
        idle(3);
        launch(AW'(16'h4000 + n * 16 + c), DW'(32'hD000_0000 + n * 256 + c * 16 + 4));
        idle(9);
      end
    end
    repeat (2) @(negedge clk);
    cmp_on = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule